// File: doc/BRIEF.md
# Byte-wide GPIO port with bus takeover and emulation routing

This block is one 8-bit general-purpose I/O port. Software sees two byte registers on a simple register bus: a latch that holds the output values, and a direction register in which a 1 turns a pin into a driven output and a 0 leaves it as a high-impedance input. The port drives pad output values and pad output enables. Pad input levels pass through a synchronizer before software can read them.

An external bus function can claim the pins. While it holds them, it supplies both the pin enables and the output values. The stored direction bits stay as they are and regain control when the claim is dropped. A second input selects emulation mode. In that mode, reads of either register return the data that the external bus interface presents. Writes still update the local register, and each one is also copied onto an outgoing write port for the external bus.

Writes take effect on the clock edge that samples the write strobe. Read data is combinational from the current address.

Top module: `gpio_bus_port`

## Requirements
- R1: After reset the direction and data registers are all zero, so with no bus takeover pad_oe and pad_out are 0 and a direction read returns 0.
- R2: A write to byte offset 0x07 loads the direction register on that clock edge. With xfn_own low, pad_oe equals the direction register bit for bit (1 = output, 0 = input).
- R3: A write to byte offset 0x03 loads the data register whatever the direction bits are. With xfn_own low, pad_out equals the data register.
- R4: While xfn_own is high, pad_oe equals xfn_oe and pad_out equals xfn_dout. Register writes still land, so the stored direction shows on pad_oe again once xfn_own falls.
- R5: With emu_mode low, a read at offset 0x07 returns the direction register.
- R6: With emu_mode low, a read at offset 0x03 returns, for each bit, the data register bit where the direction bit is 1, and otherwise the pad_in level from two clock edges earlier (two-flop synchronizer).
- R7: With emu_mode high, a read at offset 0x03 or 0x07 returns emu_rdata.
- R8: With emu_mode high, a write to offset 0x03 or 0x07 updates the register and raises emu_wr_en in the same cycle, with emu_wr_addr and emu_wr_data equal to the bus address and data. emu_wr_en is low at all other times.
- R9: A read at any other offset returns 0, and a write at any other offset changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register byte offset for reads and writes |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| pad_in | input | 8 | Pad input levels (asynchronous) |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables, 1 = drive |
| xfn_own | input | 1 | External bus function holds the pins |
| xfn_oe | input | 8 | Pin enables from the external bus function |
| xfn_dout | input | 8 | Pin values from the external bus function |
| emu_mode | input | 1 | Emulation mode select |
| emu_rdata | input | 8 | Read data from the external bus interface |
| emu_wr_en | output | 1 | Mirrored write strobe |
| emu_wr_addr | output | 4 | Mirrored write offset |
| emu_wr_data | output | 8 | Mirrored write data |

## Verification
A corrupted direction or data register shows up on pad_oe or pad_out in the cycle after the faulty write whenever no takeover is active. If a takeover is active, the fault stays hidden until xfn_own falls, and then it appears within one cycle. A register that reads back wrong, a synchronizer of the wrong depth or a swapped per-bit select shows on bus_rdata in the first cycle that the affected offset is addressed with emu_mode low. A broken mirror shows on the emu_wr outputs in the same cycle as the write.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_DIR  = 2'd2
  } reg_sel_e;

  // Map a byte offset onto one of the two registers.
  function automatic reg_sel_e decode_sel(input int unsigned addr,
                                          input int unsigned data_ofs,
                                          input int unsigned dir_ofs);
    if (addr == data_ofs)     return SEL_DATA;
    else if (addr == dir_ofs) return SEL_DIR;
    else                      return SEL_NONE;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d;
      else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  reg_sel_e         sel,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] dat_q,
  output logic [WIDTH-1:0] dir_q,
  output logic             wr_dat_hit,
  output logic             wr_dir_hit
);
  assign wr_dat_hit = wr_en && (sel == SEL_DATA);
  assign wr_dir_hit = wr_en && (sel == SEL_DIR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          dat_q <= '0;
    else if (wr_dat_hit) dat_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          dir_q <= '0;
    else if (wr_dir_hit) dir_q <= wdata;
  end
endmodule

// File: rtl/gpio_pinctl.sv
module gpio_pinctl
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  reg_sel_e         sel,
  input  logic             emu_mode,
  input  logic [WIDTH-1:0] emu_rdata,
  input  logic [WIDTH-1:0] dat_q,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] pin_sync,
  input  logic             xfn_own,
  input  logic [WIDTH-1:0] xfn_oe,
  input  logic [WIDTH-1:0] xfn_dout,
  output logic [WIDTH-1:0] rdata,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_out
);
  // Per-bit read source: latch for outputs, synchronized pad for inputs.
  function automatic logic [WIDTH-1:0] mix_read(input logic [WIDTH-1:0] dir,
                                                input logic [WIDTH-1:0] dat,
                                                input logic [WIDTH-1:0] pin);
    return (dir & dat) | (~dir & pin);
  endfunction

  function automatic logic [WIDTH-1:0] pick(input logic             own,
                                            input logic [WIDTH-1:0] ext,
                                            input logic [WIDTH-1:0] loc);
    return own ? ext : loc;
  endfunction

  assign pad_oe  = pick(xfn_own, xfn_oe, dir_q);
  assign pad_out = pick(xfn_own, xfn_dout, dat_q);

  always_comb begin
    rdata = '0;
    if (sel != SEL_NONE) begin
      if (emu_mode)            rdata = emu_rdata;
      else if (sel == SEL_DIR) rdata = dir_q;
      else                     rdata = mix_read(dir_q, dat_q, pin_sync);
    end
  end
endmodule

// File: rtl/gpio_bus_port.sv
module gpio_bus_port
  import gpio_port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int ADDR_W      = 4,
  parameter int DATA_OFS    = 3,
  parameter int DIR_OFS     = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe,
  input  logic              xfn_own,
  input  logic [WIDTH-1:0]  xfn_oe,
  input  logic [WIDTH-1:0]  xfn_dout,
  input  logic              emu_mode,
  input  logic [WIDTH-1:0]  emu_rdata,
  output logic              emu_wr_en,
  output logic [ADDR_W-1:0] emu_wr_addr,
  output logic [WIDTH-1:0]  emu_wr_data
);
  reg_sel_e         sel;
  logic [WIDTH-1:0] dat_q;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] pin_sync;
  logic             wr_dat_hit;
  logic             wr_dir_hit;

  assign sel = decode_sel(int'(unsigned'(bus_addr)), DATA_OFS, DIR_OFS);

  gpio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (bus_wr),
    .sel        (sel),
    .wdata      (bus_wdata),
    .dat_q      (dat_q),
    .dir_q      (dir_q),
    .wr_dat_hit (wr_dat_hit),
    .wr_dir_hit (wr_dir_hit)
  );

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (pin_sync)
  );

  gpio_pinctl #(.WIDTH(WIDTH)) u_pin (
    .sel       (sel),
    .emu_mode  (emu_mode),
    .emu_rdata (emu_rdata),
    .dat_q     (dat_q),
    .dir_q     (dir_q),
    .pin_sync  (pin_sync),
    .xfn_own   (xfn_own),
    .xfn_oe    (xfn_oe),
    .xfn_dout  (xfn_dout),
    .rdata     (bus_rdata),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out)
  );

  // Mirror of mapped writes toward the external bus in emulation mode.
  assign emu_wr_en   = emu_mode && (wr_dat_hit || wr_dir_hit);
  assign emu_wr_addr = bus_addr;
  assign emu_wr_data = bus_wdata;
endmodule

// File: rtl/gpio_bus_port_chk.sv
module gpio_bus_port_chk #(
  parameter int WIDTH    = 8,
  parameter int ADDR_W   = 4,
  parameter int DATA_OFS = 3,
  parameter int DIR_OFS  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [WIDTH-1:0]  bus_wdata,
  input logic [WIDTH-1:0]  bus_rdata,
  input logic [WIDTH-1:0]  pad_in,
  input logic [WIDTH-1:0]  pad_out,
  input logic [WIDTH-1:0]  pad_oe,
  input logic              xfn_own,
  input logic [WIDTH-1:0]  xfn_oe,
  input logic [WIDTH-1:0]  xfn_dout,
  input logic              emu_mode,
  input logic [WIDTH-1:0]  emu_rdata,
  input logic              emu_wr_en,
  input logic [ADDR_W-1:0] emu_wr_addr,
  input logic [WIDTH-1:0]  emu_wr_data,
  input logic [WIDTH-1:0]  dat_q,
  input logic [WIDTH-1:0]  dir_q,
  input logic [WIDTH-1:0]  pin_sync,
  input logic              wr_dat_hit,
  input logic              wr_dir_hit
);
  logic       hit_any;
  logic [1:0] age_q;

  assign hit_any = (int'(unsigned'(bus_addr)) == DATA_OFS) ||
                   (int'(unsigned'(bus_addr)) == DIR_OFS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age_q <= '0;
    else if (age_q != 3) age_q <= age_q + 2'd1;
  end

  // R2
  dir_to_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && int'(unsigned'(bus_addr)) == DIR_OFS) |=> (xfn_own || pad_oe == $past(bus_wdata)));

  // R3
  dat_to_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dat_hit |=> (xfn_own || pad_out == $past(bus_wdata)));

  // R4
  takeover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfn_own |-> (pad_oe == xfn_oe && pad_out == xfn_dout));

  // R5
  dir_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!emu_mode && int'(unsigned'(bus_addr)) == DIR_OFS) |-> bus_rdata == dir_q);

  // R6
  sync_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2) |-> pin_sync == $past(pad_in, 2));

  // R7
  emu_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (emu_mode && hit_any) |-> bus_rdata == emu_rdata);

  // R8
  mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    emu_wr_en |-> (emu_mode && bus_wr && hit_any && emu_wr_addr == bus_addr && emu_wr_data == bus_wdata));

  // R8
  mirror_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (emu_mode && (wr_dat_hit || wr_dir_hit)) |-> emu_wr_en);

  // R9
  unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !hit_any) |=> ($stable(dat_q) && $stable(dir_q)));

  // R9
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_any |-> bus_rdata == '0);
endmodule

bind gpio_bus_port gpio_bus_port_chk #(
  .WIDTH(WIDTH), .ADDR_W(ADDR_W), .DATA_OFS(DATA_OFS), .DIR_OFS(DIR_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
  .pad_out(pad_out), .pad_oe(pad_oe), .xfn_own(xfn_own), .xfn_oe(xfn_oe),
  .xfn_dout(xfn_dout), .emu_mode(emu_mode), .emu_rdata(emu_rdata),
  .emu_wr_en(emu_wr_en), .emu_wr_addr(emu_wr_addr), .emu_wr_data(emu_wr_data),
  .dat_q(dat_q), .dir_q(dir_q), .pin_sync(pin_sync),
  .wr_dat_hit(wr_dat_hit), .wr_dir_hit(wr_dir_hit)
);

// File: tb/sim_gpio_bus_port.sv
`timescale 1ns/1ps
module sim_gpio_bus_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pad_in = '0;
  logic [7:0] pad_out, pad_oe;
  logic       xfn_own = 1'b0;
  logic [7:0] xfn_oe = '0, xfn_dout = '0;
  logic       emu_mode = 1'b0;
  logic [7:0] emu_rdata = '0;
  logic       emu_wr_en;
  logic [3:0] emu_wr_addr;
  logic [7:0] emu_wr_data;

  int vecs = 0;
  int errs = 0;
  bit done = 0;

  // Bench-side state derived from the requirements.
  logic [7:0] m_dir = '0, m_dat = '0, m_s1 = '0, m_s2 = '0;

  always #5 clk = ~clk;

  gpio_bus_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .xfn_own(xfn_own), .xfn_oe(xfn_oe),
    .xfn_dout(xfn_dout), .emu_mode(emu_mode), .emu_rdata(emu_rdata),
    .emu_wr_en(emu_wr_en), .emu_wr_addr(emu_wr_addr), .emu_wr_data(emu_wr_data)
  );

  function automatic logic [7:0] exp_read();
    if (bus_addr != 4'd3 && bus_addr != 4'd7) return 8'h00;
    if (emu_mode) return emu_rdata;
    if (bus_addr == 4'd7) return m_dir;
    // input bits come from the synchronized pad, output bits from the latch
    return (m_dat & m_dir) | (m_s2 & ~m_dir);
  endfunction

  function automatic string read_tag();
    if (bus_addr != 4'd3 && bus_addr != 4'd7) return "R9";
    if (emu_mode) return "R7";
    return (bus_addr == 4'd7) ? "R5" : "R6";
  endfunction

  task automatic check8(input string tag, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  task automatic check_all();
    logic mapped;
    mapped = (bus_addr == 4'd3 || bus_addr == 4'd7);
    check8(read_tag(), "bus_rdata", bus_rdata, exp_read());
    check8(xfn_own ? "R4" : "R2", "pad_oe", pad_oe, xfn_own ? xfn_oe : m_dir);
    check8(xfn_own ? "R4" : "R3", "pad_out", pad_out, xfn_own ? xfn_dout : m_dat);
    check8("R8", "emu_wr_en", {7'd0, emu_wr_en}, {7'd0, emu_mode & bus_wr & mapped});
    if (emu_mode && bus_wr && mapped) begin
      check8("R8", "emu_wr_addr", {4'd0, emu_wr_addr}, {4'd0, bus_addr});
      check8("R8", "emu_wr_data", emu_wr_data, bus_wdata);
    end
  endtask

  // Inputs change at the falling edge, outputs are compared 1 ns later,
  // and the bench state advances at the rising edge.
  task automatic step(input logic [3:0] a, input logic w, input logic [7:0] wd,
                      input logic [7:0] pin, input logic own, input logic [7:0] xoe,
                      input logic [7:0] xdo, input logic emu, input logic [7:0] erd);
    @(negedge clk);
    bus_addr = a; bus_wr = w; bus_wdata = wd; pad_in = pin;
    xfn_own = own; xfn_oe = xoe; xfn_dout = xdo; emu_mode = emu; emu_rdata = erd;
    #1;
    check_all();
    @(posedge clk);
    if (w && a == 4'd3) m_dat = wd;
    if (w && a == 4'd7) m_dir = wd;
    m_s2 = m_s1;
    m_s1 = pin;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset values seen at the ports
    check8("R1", "reset pad_oe", pad_oe, 8'h00);
    check8("R1", "reset pad_out", pad_out, 8'h00);
    bus_addr = 4'd7;
    #1;
    check8("R1", "reset dir read", bus_rdata, 8'h00);

    // R3: preload data while all pins are inputs, then R2: enable outputs
    step(4'd3, 1, 8'hA5, 8'h3C, 0, 8'h00, 8'h00, 0, 8'h00);
    step(4'd7, 1, 8'h0F, 8'h3C, 0, 8'h00, 8'h00, 0, 8'h00);
    step(4'd3, 0, 8'h00, 8'h3C, 0, 8'h00, 8'h00, 0, 8'h00); // R6 mixed read
    // R4: takeover, direction write during takeover, then release
    step(4'd7, 1, 8'hF0, 8'h00, 1, 8'h5A, 8'hC3, 0, 8'h00);
    step(4'd7, 0, 8'h00, 8'h00, 1, 8'h5A, 8'hC3, 0, 8'h00);
    step(4'd7, 0, 8'h00, 8'h00, 0, 8'h00, 8'h00, 0, 8'h00); // R4 stored dir returns
    // R7, R8: emulation read and mirrored write
    step(4'd7, 1, 8'h81, 8'h00, 0, 8'h00, 8'h00, 1, 8'h99);
    step(4'd3, 0, 8'h00, 8'h00, 0, 8'h00, 8'h00, 1, 8'h66);
    // R9: unmapped write and read
    step(4'd5, 1, 8'hFF, 8'hFF, 0, 8'h00, 8'h00, 0, 8'h00);
    step(4'd5, 0, 8'h00, 8'hFF, 0, 8'h00, 8'h00, 1, 8'h77);
    step(4'd3, 0, 8'h00, 8'hFF, 0, 8'h00, 8'h00, 0, 8'h00);

    for (int i = 0; i < 3000; i++) begin
      logic [3:0] a;
      int r;
      r = $urandom_range(0, 9);
      a = (r < 4) ? 4'd3 : (r < 8) ? 4'd7 : 4'($urandom);
      step(a, 1'($urandom), 8'($urandom), 8'($urandom),
           $urandom_range(0, 3) == 0, 8'($urandom), 8'($urandom),
           $urandom_range(0, 3) == 0, 8'($urandom));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errs++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule